// File: doc/BRIEF.md
# Per-Output Source-Select Crosspoint

The crosspoint routes tributary signal bundles between eight functional groups. Every output channel owns an 8-bit source identifier register. The upper three bits of the register name a source group. The lower five bits name a channel inside that group. Each output lane reads its identifier, picks the matching input bundle and registers it once before it reaches the destination. The selection is held per output, so two writes can never collide. Any number of outputs may name the same source, which gives broadcast.

Each bundle is six lines wide and is switched as a unit:
- bit 0: data
- bit 1: clock
- bit 2: frame sync (or stuff frequency)
- bit 3: automatic AIS
- bit 4: remote alarm
- bit 5: pointer adjust

Group 0 is the external I/O group and carries 29 channels. Every other group carries 28 channels. Each group still decodes 32 identifier slots.

A selection is rejected when any of these holds:
- the channel is out of range for the source group;
- the source/destination group pair is forbidden by the legality map;
- a group loops back onto itself with reordering;
- E1 mode is on and the channel number is a multiple of four.

A rejected selection drives the AIS bundle and sets a sticky per-output error flag. Software programs the identifiers through a simple write port and reads them back through a read port. The read port also returns the addressed output's error flag.

Top module: `xc_crosspoint`

## Requirements
- R1: After reset every identifier reads 8'hFF (unconnected). Every output drives the AIS bundle 6'b001001 (data=1, auto-AIS=1, other lines 0), and every error flag reads 0.
- R2: A write to address {dst_group[2:0], dst_channel[4:0]} is readable on the same address in the next cycle. The read returns the exact value written, including illegal values.
- R3: With a legal identifier {src_group[2:0], src_channel[4:0]}, the output bundle equals the source bundle at slot src_group*32+src_channel, delayed by one clock. All six lines follow together.
- R4: Several outputs holding the same identifier all carry that same source bundle.
- R5: A source channel of 29 or more in group 0, or 28 or more in any other group, gives the AIS bundle and sets the output's error flag.
- R6: The default legality map forbids source group 1 to destination group 2 and source group 3 to destination group 5. Either pair gives AIS and sets the error flag.
- R7: A destination group may select from its own group only at the same channel number. Any other channel from its own group gives AIS and sets the error flag.
- R8: When e1_mode is 1, a source channel whose two low bits are 00 gives AIS and sets the error flag. When e1_mode is 0, the same channel passes through.
- R9: The error flag stays set until software writes that output's identifier; the write clears it. The unconnected value 8'hFF never sets the flag.
- R10: An output channel at or above its own group's channel count (29 for group 0, 28 otherwise) always drives AIS. It never raises its error flag.
- R11: A write sampled at clock edge k changes the output bundle at edge k+1. Between those edges the output still shows the previous selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e1_mode | input | 1 | 1 rejects source channels whose two low bits are 00 |
| cfg_we | input | 1 | Identifier write strobe |
| cfg_addr | input | 8 | Output address {group, channel} for write and read |
| cfg_wdata | input | 8 | Identifier to store |
| cfg_rdata | output | 8 | Stored identifier at cfg_addr |
| cfg_rerr | output | 1 | Sticky error flag of the output at cfg_addr |
| src_bus | input | 1536 | 256 source bundles of 6 bits, slot = group*32+channel |
| dst_bus | output | 1536 | 256 registered output bundles, same slot layout |

## Verification
The hardest condition to reach from the ports is a sticky error flag that outlives its cause. It can only be seen when an illegal selection becomes legal without a write to that output. The stimulus gets there by changing e1_mode alone:
1. An output is programmed with a multiple-of-four channel while E1 mode is on, which raises its flag.
2. E1 mode is turned off, so the stored selection becomes legal and the data passes through.
3. The bench checks that the data now passes but the flag still reads 1.
4. Only a rewrite of that output's identifier clears the flag.

The bench then sets different source patterns while the identifiers stay fixed. This proves that the six bundle lines follow the source together.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int BUNDLE_W = 6;
    localparam int B_DATA   = 0;
    localparam int B_CLK    = 1;
    localparam int B_SYNC   = 2;
    localparam int B_AIS    = 3;
    localparam int B_RAI    = 4;
    localparam int B_PADJ   = 5;

    typedef logic [BUNDLE_W-1:0] bundle_t;

    localparam bundle_t AIS_BUNDLE = bundle_t'((1 << B_DATA) | (1 << B_AIS));

    function automatic int grp_chans(input int grp, input int ext_grp,
                                     input int ext_ch, input int std_ch);
        return (grp == ext_grp) ? ext_ch : std_ch;
    endfunction
endpackage

// File: rtl/xc_id_regs.sv
module xc_id_regs #(
    parameter int NUM_OUT = 256,
    parameter int ID_W    = 8,
    localparam int ADDR_W = $clog2(NUM_OUT)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [ID_W-1:0]         wdata,
    output logic [ID_W-1:0]         rdata,
    output logic [NUM_OUT*ID_W-1:0] ids,
    output logic [NUM_OUT-1:0]      wr_hit
);
    localparam logic [ID_W-1:0] UNCONN = '1;

    typedef struct packed {
        logic [NUM_OUT-1:0][ID_W-1:0] id;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        wr_hit = '0;
        if (we) begin
            r_d.id[addr] = wdata;
            wr_hit[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OUT; i++) r_q.id[i] <= UNCONN;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdata = r_q.id[addr];
    assign ids   = r_q.id;

    // R2: the write lands on exactly the addressed identifier
    p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (r_q.id[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/xc_out_lane.sv
module xc_out_lane
    import xc_pkg::*;
#(
    parameter int          NUM_GRP   = 8,
    parameter int          SLOTS     = 32,
    parameter int          STD_CH    = 28,
    parameter int          EXT_CH    = 29,
    parameter int          EXT_GRP   = 0,
    parameter logic [63:0] LEGAL_MAP = 64'hFFFF_FFFF_DFFF_FBFF,
    parameter int          DST_GRP   = 0,
    parameter int          DST_CH    = 0,
    localparam int GRP_W = $clog2(NUM_GRP),
    localparam int CH_W  = $clog2(SLOTS),
    localparam int ID_W  = GRP_W + CH_W,
    localparam int BUS_W = NUM_GRP * SLOTS * BUNDLE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            e1_mode,
    input  logic [ID_W-1:0] id,
    input  logic            wr_hit,
    input  logic [BUS_W-1:0] src_bus,
    output bundle_t         bundle_o,
    output logic            err_o
);
    localparam logic [ID_W-1:0] UNCONN = '1;
    localparam bit DST_USED =
        DST_CH < grp_chans(DST_GRP, EXT_GRP, EXT_CH, STD_CH);

    typedef struct packed {
        bundle_t bundle;
        logic    err;
    } lane_t;

    lane_t l_d, l_q;

    logic [GRP_W-1:0] s_grp;
    logic [CH_W-1:0]  s_ch;
    logic             range_ok, pair_ok, loop_ok, e1_ok;
    logic             unconn, sel_ok, bad_evt;
    bundle_t          src_sel;

    always_comb begin
        s_grp    = id[ID_W-1:CH_W];
        s_ch     = id[CH_W-1:0];
        unconn   = (id == UNCONN);
        range_ok = int'(s_ch) < grp_chans(int'(s_grp), EXT_GRP, EXT_CH, STD_CH);
        pair_ok  = LEGAL_MAP[int'(s_grp) * NUM_GRP + DST_GRP];
        loop_ok  = (int'(s_grp) != DST_GRP) || (int'(s_ch) == DST_CH);
        e1_ok    = !e1_mode || (s_ch[1:0] != 2'b00);
        src_sel  = src_bus[int'(id) * BUNDLE_W +: BUNDLE_W];
        sel_ok   = DST_USED && !unconn && range_ok && pair_ok && loop_ok && e1_ok;
        bad_evt  = DST_USED && !unconn && !(range_ok && pair_ok && loop_ok && e1_ok);

        l_d.bundle = sel_ok ? src_sel : AIS_BUNDLE;
        if (wr_hit) l_d.err = 1'b0;
        else        l_d.err = l_q.err | bad_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q.bundle <= AIS_BUNDLE;
            l_q.err    <= 1'b0;
        end else begin
            l_q <= l_d;
        end
    end

    assign bundle_o = l_q.bundle;
    assign err_o    = l_q.err;

    // R9: once raised, the flag holds until the output is rewritten
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.err && !wr_hit) |=> l_q.err);
    // R9: a write to this output clears its flag
    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> !l_q.err);
    // R9: an unconnected identifier never raises the flag
    p_unconn_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (unconn && !l_q.err) |=> !l_q.err);
    // R5: a rejected selection shows AIS and a raised flag one cycle later
    p_bad_gives_ais_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_evt && !wr_hit) |=> (l_q.bundle == AIS_BUNDLE && l_q.err));
    // R3: an accepted selection passes the source bundle one cycle later
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ok |=> (l_q.bundle == $past(src_sel)));
endmodule

// File: rtl/xc_crosspoint.sv
module xc_crosspoint
    import xc_pkg::*;
#(
    parameter int          NUM_GRP   = 8,
    parameter int          SLOTS     = 32,
    parameter int          STD_CH    = 28,
    parameter int          EXT_CH    = 29,
    parameter int          EXT_GRP   = 0,
    parameter logic [63:0] LEGAL_MAP = 64'hFFFF_FFFF_DFFF_FBFF,
    localparam int GRP_W   = $clog2(NUM_GRP),
    localparam int CH_W    = $clog2(SLOTS),
    localparam int ID_W    = GRP_W + CH_W,
    localparam int NUM_OUT = NUM_GRP * SLOTS,
    localparam int BUS_W   = NUM_OUT * BUNDLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             e1_mode,
    input  logic             cfg_we,
    input  logic [ID_W-1:0]  cfg_addr,
    input  logic [ID_W-1:0]  cfg_wdata,
    output logic [ID_W-1:0]  cfg_rdata,
    output logic             cfg_rerr,
    input  logic [BUS_W-1:0] src_bus,
    output logic [BUS_W-1:0] dst_bus
);
    logic [NUM_OUT*ID_W-1:0] ids;
    logic [NUM_OUT-1:0]      wr_hit;
    logic [NUM_OUT-1:0]      err_vec;

    xc_id_regs #(.NUM_OUT(NUM_OUT), .ID_W(ID_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .ids    (ids),
        .wr_hit (wr_hit)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar c = 0; c < SLOTS; c++) begin : g_ch
            localparam int IDX = g * SLOTS + c;
            xc_out_lane #(
                .NUM_GRP(NUM_GRP), .SLOTS(SLOTS), .STD_CH(STD_CH),
                .EXT_CH(EXT_CH), .EXT_GRP(EXT_GRP), .LEGAL_MAP(LEGAL_MAP),
                .DST_GRP(g), .DST_CH(c)
            ) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .e1_mode  (e1_mode),
                .id       (ids[IDX*ID_W +: ID_W]),
                .wr_hit   (wr_hit[IDX]),
                .src_bus  (src_bus),
                .bundle_o (dst_bus[IDX*BUNDLE_W +: BUNDLE_W]),
                .err_o    (err_vec[IDX])
            );
        end
    end

    assign cfg_rerr = err_vec[cfg_addr];
endmodule

// File: tb/xc_crosspoint_test.sv
module xc_crosspoint_test;
    localparam int NG = 8;
    localparam int NS = 32;
    localparam int BW = 6;
    localparam logic [5:0] AIS = 6'b001001;

    typedef struct {
        string      tag;
        int         idx;
        logic [5:0] exp_b;
        logic       exp_err;
        logic [7:0] exp_id;
    } item_t;

    logic clk = 0, rst_n = 0, e1_mode = 0, cfg_we = 0;
    logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
    logic cfg_rerr;
    logic [NG*NS*BW-1:0] src_bus = '0, dst_bus;
    int n_chk = 0, n_fail = 0, salt = 0;
    item_t q[$];
    bit done = 0;

    always #2.5 clk = ~clk;

    xc_crosspoint uut (
        .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_rerr(cfg_rerr), .src_bus(src_bus), .dst_bus(dst_bus)
    );

    function automatic logic [5:0] pat(int g, int c, int s);
        logic [5:0] v = 6'((g * 5 + c * 11 + s * 23 + 1) & 63);
        return (v == AIS) ? 6'd54 : v;
    endfunction

    function automatic int chans(int g);
        return (g == 0) ? 29 : 28;
    endfunction

    function automatic bit bad(int dg, int dc, logic [7:0] id, logic e1);
        int sg = int'(id[7:5]);
        int sc = int'(id[4:0]);
        if (id == 8'hFF || dc >= chans(dg)) return 0;
        return !(sc < chans(sg) && !(sg == 1 && dg == 2) && !(sg == 3 && dg == 5)
                 && (sg != dg || sc == dc) && (!e1 || sc % 4 != 0));
    endfunction

    function automatic logic [5:0] model(int dg, int dc, logic [7:0] id, logic e1);
        if (id == 8'hFF || dc >= chans(dg) || bad(dg, dc, id, e1)) return AIS;
        return pat(int'(id[7:5]), int'(id[4:0]), salt);
    endfunction

    task automatic set_src(int s);
        salt = s;
        for (int g = 0; g < NG; g++)
            for (int c = 0; c < NS; c++)
                src_bus[(g*NS+c)*BW +: BW] = pat(g, c, s);
    endtask

    task automatic wr(int dg, int dc, logic [7:0] id);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 8'(dg*NS + dc); cfg_wdata = id;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic expect_item(string tag, int dg, int dc, logic [5:0] b,
                               logic e, logic [7:0] id);
        item_t it;
        cfg_addr = 8'(dg*NS + dc);
        #0.5;
        it.tag = tag; it.idx = dg*NS + dc; it.exp_b = b; it.exp_err = e; it.exp_id = id;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    // program, let the output register settle, then compare against the model
    task automatic route(string tag, int dg, int dc, logic [7:0] id);
        wr(dg, dc, id);
        @(negedge clk);
        expect_item(tag, dg, dc, model(dg, dc, id, e1_mode),
                    bad(dg, dc, id, e1_mode), id);
    endtask

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            item_t it;
            logic [5:0] act;
            wait (q.size() > 0);
            it = q[0];
            act = dst_bus[it.idx*BW +: BW];
            n_chk++;
            if (act !== it.exp_b || cfg_rerr !== it.exp_err || cfg_rdata !== it.exp_id) begin
                n_fail++;
                $display("FAIL %s out=%0d bundle=%b/%b err=%b/%b id=%h/%h (act/exp)",
                         it.tag, it.idx, act, it.exp_b, cfg_rerr, it.exp_err,
                         cfg_rdata, it.exp_id);
            end
            void'(q.pop_front());
        end
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        set_src(0);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        expect_item("R1", 0, 0, AIS, 0, 8'hFF);
        expect_item("R1", 5, 17, AIS, 0, 8'hFF);
        expect_item("R1", 7, 31, AIS, 0, 8'hFF);
        // R2 readback, including an illegal value
        wr(2, 5, 8'hFE);
        expect_item("R2", 2, 5, AIS, 0, 8'hFE);
        // R3 legal pass and line-by-line follow
        route("R3", 2, 5, {3'd3, 5'd7});
        set_src(1);
        @(negedge clk);
        expect_item("R3", 2, 5, pat(3, 7, 1), 0, {3'd3, 5'd7});
        // R11: new selection appears one edge after the write edge
        wr(2, 5, {3'd4, 5'd2});
        expect_item("R11", 2, 5, pat(3, 7, 1), 0, {3'd4, 5'd2});
        @(negedge clk);
        expect_item("R11", 2, 5, pat(4, 2, 1), 0, {3'd4, 5'd2});
        // R4 broadcast
        wr(4, 0, {3'd1, 5'd3});
        wr(4, 1, {3'd1, 5'd3});
        wr(6, 9, {3'd1, 5'd3});
        @(negedge clk);
        expect_item("R4", 4, 0, pat(1, 3, 1), 0, {3'd1, 5'd3});
        expect_item("R4", 4, 1, pat(1, 3, 1), 0, {3'd1, 5'd3});
        expect_item("R4", 6, 9, pat(1, 3, 1), 0, {3'd1, 5'd3});
        // R5 range
        route("R5", 4, 6, {3'd0, 5'd28});
        route("R5", 4, 7, {3'd1, 5'd28});
        route("R5", 4, 8, {3'd0, 5'd29});
        // R6 legality map
        route("R6", 2, 9, {3'd1, 5'd4});
        route("R6", 5, 2, {3'd3, 5'd2});
        route("R6", 5, 3, {3'd4, 5'd2});
        // R7 loopback
        route("R7", 3, 4, {3'd3, 5'd4});
        route("R7", 3, 5, {3'd3, 5'd6});
        // R8 E1 channel skipping
        e1_mode = 1;
        route("R8", 6, 1, {3'd2, 5'd8});
        route("R8", 6, 2, {3'd2, 5'd9});
        e1_mode = 0;
        route("R8", 6, 3, {3'd2, 5'd8});
        // R9 sticky: cause removed without a write, flag persists
        e1_mode = 1;
        route("R9", 6, 4, {3'd2, 5'd12});
        e1_mode = 0;
        @(negedge clk); @(negedge clk);
        expect_item("R9", 6, 4, pat(2, 12, 1), 1, {3'd2, 5'd12});
        wr(6, 4, {3'd2, 5'd12});
        @(negedge clk);
        expect_item("R9", 6, 4, pat(2, 12, 1), 0, {3'd2, 5'd12});
        route("R9", 6, 4, 8'hFF);
        // R10 unused destination channels
        route("R10", 1, 29, {3'd2, 5'd3});
        route("R10", 0, 28, {3'd2, 5'd3});
        route("R10", 0, 31, {3'd7, 5'd31});
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule